// File: doc/BRIEF.md
# Indexed-Colour Palette Loader

This block fills the colour lookup table of an indexed-colour display pipeline. A frame whose command requests a palette makes the surrounding frame logic pulse a start strobe. The DMA engine then streams raw palette words into the block. Each entry is unpacked according to the selected palette layout and an optional monochrome mode. The result is an 8-bit red, green and blue value plus a transparency flag, written into a 256-entry table. The pixel pipeline reads that table by index through a registered read port.

How many entries are loaded follows from the pixel-depth code in the display control word. The depth code is four bits: bits 26:24 of the control word form its low three bits, and bit 29 is its top bit. Only the 2, 4 and 8 bits-per-pixel depths use a palette. A reload request output tells the frame logic when the palette layout setting has changed since the last load started, so that it can schedule a fresh palette fetch.

Top module: `pal_loader`

## Requirements
- R1: The depth code is {ctrl_word_i[29], ctrl_word_i[26:24]}. Code 1 loads 4 entries, code 2 loads 16 and code 3 loads 256, written to indices 0 upward. Any other code (including codes with bit 29 set) accepts no words and leaves the table unchanged.
- R2: Layout 0 (pal_fmt_i = 0) takes 16-bit entries: red from bits 15:11, green from 10:5 and blue from 4:0, each shifted left to fill 8 bits with zeros below. Transparency is 0.
- R3: Layout 1 takes 32-bit entries: transparency from bit 24, red from 23:19, green from 15:10 and blue from 7:3, left-aligned to 8 bits.
- R4: Layout 2 takes 32-bit entries: transparency from bit 24, red from 23:18, green from 15:10 and blue from 7:2, left-aligned to 8 bits.
- R5: Layout 3 takes 32-bit entries: transparency from bit 24, red from 23:16, green from 15:8 and blue from 7:0.
- R6: With mono_i set at start, red, green and blue all take bits 7:0 of the entry. In layouts 1 to 3 transparency still comes from bit 24.
- R7: In layout 0 each word carries two entries, bits 15:0 first and then bits 31:16. word_ready_o is low for the one cycle after each accepted word while the second half is written.
- R8: load_done_o is high for exactly one cycle. That cycle is the one after the clock edge that writes the last entry. For a depth that loads nothing, it is the cycle after the start edge.
- R9: word_ready_o is low whenever no load is in progress. Words offered then are not taken and change no entry.
- R10: reload_req_o is high after reset until the first start. After that it is high exactly when pal_fmt_i differs from the layout captured at the most recent start.
- R11: The read port returns the entry at rd_idx_i on the clock edge after the index is presented.
- R12: Reset clears all entries and the read data to zero, and drops word_ready_o and load_done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_word_i | input | 32 | Display control word carrying the depth code |
| pal_fmt_i | input | 2 | Palette entry layout selector |
| mono_i | input | 1 | Monochrome mode, low byte to all channels |
| pal_start_i | input | 1 | Starts a palette load; layout, mode and depth are captured |
| word_valid_i | input | 1 | Palette word valid from the DMA engine |
| word_i | input | 32 | Palette data word |
| word_ready_o | output | 1 | Block accepts word_i this cycle |
| load_done_o | output | 1 | One-cycle pulse after the last entry is written |
| reload_req_o | output | 1 | Layout setting differs from the one last loaded |
| rd_idx_i | input | 8 | Lookup index from the pixel pipeline |
| rd_red_o | output | 8 | Red of the looked-up entry |
| rd_green_o | output | 8 | Green of the looked-up entry |
| rd_blue_o | output | 8 | Blue of the looked-up entry |
| rd_transp_o | output | 1 | Transparency flag of the looked-up entry |

## Verification
A word accepted on a clock edge is written into the table on that same edge. The second half of a layout-0 word is written one edge later. The done pulse appears in the cycle after the final write, so it comes one cycle after the last handshake, or two in layout 0. A lookup shows on the outputs one edge after its index is presented, while reload_req_o follows pal_fmt_i with no delay. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares every output shortly after each falling edge, so each result is checked in the cycle it is due. Directed checks measure the handshake count and the gap to the done pulse in falling edges.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    FMT_565  = 2'd0,
    FMT_555T = 2'd1,
    FMT_666T = 2'd2,
    FMT_888T = 2'd3
  } pal_fmt_e;

  typedef struct packed {
    logic       transp;
    logic [7:0] red;
    logic [7:0] green;
    logic [7:0] blue;
  } pal_entry_t;

  // entries implied by a pixel-depth code; zero means no palette
  function automatic int unsigned depth_entries(logic [3:0] code);
    case (code)
      4'd1:    return 4;
      4'd2:    return 16;
      4'd3:    return 256;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pal_decode.sv
module pal_decode
  import pal_pkg::*;
(
  input  logic [31:0] raw_i,
  input  pal_fmt_e    fmt_i,
  input  logic        mono_i,
  output pal_entry_t  entry_o
);

  always_comb begin
    entry_o = '0;
    if (fmt_i == FMT_565) begin
      entry_o.transp = 1'b0;
      if (mono_i) begin
        entry_o.red   = raw_i[7:0];
        entry_o.green = raw_i[7:0];
        entry_o.blue  = raw_i[7:0];
      end else begin
        entry_o.red   = {raw_i[15:11], 3'b000};
        entry_o.green = {raw_i[10:5], 2'b00};
        entry_o.blue  = {raw_i[4:0], 3'b000};
      end
    end else begin
      entry_o.transp = raw_i[24];
      if (mono_i) begin
        entry_o.red   = raw_i[7:0];
        entry_o.green = raw_i[7:0];
        entry_o.blue  = raw_i[7:0];
      end else begin
        case (fmt_i)
          FMT_555T: begin
            entry_o.red   = {raw_i[23:19], 3'b000};
            entry_o.green = {raw_i[15:10], 2'b00};
            entry_o.blue  = {raw_i[7:3], 3'b000};
          end
          FMT_666T: begin
            entry_o.red   = {raw_i[23:18], 2'b00};
            entry_o.green = {raw_i[15:10], 2'b00};
            entry_o.blue  = {raw_i[7:2], 2'b00};
          end
          default: begin
            entry_o.red   = raw_i[23:16];
            entry_o.green = raw_i[15:8];
            entry_o.blue  = raw_i[7:0];
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W:0]   n_entries_i,
  input  pal_fmt_e         fmt_i,
  input  logic             mono_i,
  input  logic             valid_i,
  input  logic [31:0]      data_i,
  output logic             ready_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [31:0]      wr_raw_o,
  output pal_fmt_e         lat_fmt_o,
  output logic             lat_mono_o,
  output logic             half_o,
  output logic             done_o
);

  logic             busy_q, half_q, done_q, mono_q;
  logic [15:0]      hi_q;
  logic [IDX_W:0]   cnt_q;
  logic [IDX_W-1:0] idx_q;
  pal_fmt_e         fmt_q;
  logic             accept, last;

  assign ready_o = busy_q & ~half_q;
  assign accept  = ready_o & valid_i;
  assign wr_en_o = ~start_i & (half_q | accept);
  assign last    = (cnt_q == (IDX_W+1)'(1));

  always_comb begin
    if (half_q)                wr_raw_o = {16'h0000, hi_q};
    else if (fmt_q == FMT_565) wr_raw_o = {16'h0000, data_i[15:0]};
    else                       wr_raw_o = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      done_q <= 1'b0;
      mono_q <= 1'b0;
      hi_q   <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      fmt_q  <= FMT_565;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        fmt_q  <= fmt_i;
        mono_q <= mono_i;
        cnt_q  <= n_entries_i;
        idx_q  <= '0;
        half_q <= 1'b0;
        busy_q <= (n_entries_i != '0);
        done_q <= (n_entries_i == '0);
      end else if (wr_en_o) begin
        idx_q <= idx_q + 1'b1;
        cnt_q <= cnt_q - 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          half_q <= 1'b0;
          done_q <= 1'b1;
        end else if (!half_q && fmt_q == FMT_565) begin
          half_q <= 1'b1;
          hi_q   <= data_i[31:16];
        end else begin
          half_q <= 1'b0;
        end
      end
    end
  end

  assign wr_idx_o   = idx_q;
  assign lat_fmt_o  = fmt_q;
  assign lat_mono_o = mono_q;
  assign half_o     = half_q;
  assign done_o     = done_q;

endmodule

// File: rtl/pal_ram.sv
module pal_ram
  import pal_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned IDX_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  pal_entry_t       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output pal_entry_t       rdata_o
);

  pal_entry_t mem [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g))         mem[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/pal_loader.sv
module pal_loader
  import pal_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      ctrl_word_i,
  input  logic [1:0]       pal_fmt_i,
  input  logic             mono_i,
  input  logic             pal_start_i,
  input  logic             word_valid_i,
  input  logic [31:0]      word_i,
  output logic             word_ready_o,
  output logic             load_done_o,
  output logic             reload_req_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_red_o,
  output logic [7:0]       rd_green_o,
  output logic [7:0]       rd_blue_o,
  output logic             rd_transp_o
);

  function automatic logic [IDX_W:0] entries_for(logic [3:0] code);
    int unsigned n;
    n = depth_entries(code);
    if (n > ENTRIES) n = ENTRIES;
    return (IDX_W+1)'(n);
  endfunction

  logic [3:0]       depth_code;
  logic [IDX_W:0]   n_entries;
  logic             wr_en, half, lat_mono;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      wr_raw;
  pal_fmt_e         lat_fmt, fmt_in;
  pal_entry_t       wr_entry, rd_entry;
  logic             loaded_q;
  pal_fmt_e         last_fmt_q;
  logic             unused_ctrl;

  assign depth_code  = {ctrl_word_i[29], ctrl_word_i[26:24]};
  assign unused_ctrl = ^{ctrl_word_i[31:30], ctrl_word_i[28:27], ctrl_word_i[23:0]};
  assign n_entries   = entries_for(depth_code);
  assign fmt_in      = pal_fmt_e'(pal_fmt_i);

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (pal_start_i),
    .n_entries_i (n_entries),
    .fmt_i       (fmt_in),
    .mono_i      (mono_i),
    .valid_i     (word_valid_i),
    .data_i      (word_i),
    .ready_o     (word_ready_o),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_raw_o    (wr_raw),
    .lat_fmt_o   (lat_fmt),
    .lat_mono_o  (lat_mono),
    .half_o      (half),
    .done_o      (load_done_o)
  );

  pal_decode u_dec (
    .raw_i   (wr_raw),
    .fmt_i   (lat_fmt),
    .mono_i  (lat_mono),
    .entry_o (wr_entry)
  );

  pal_ram #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .waddr_i (wr_idx),
    .wdata_i (wr_entry),
    .raddr_i (rd_idx_i),
    .rdata_o (rd_entry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q   <= 1'b0;
      last_fmt_q <= FMT_565;
    end else if (pal_start_i) begin
      loaded_q   <= 1'b1;
      last_fmt_q <= fmt_in;
    end
  end

  assign reload_req_o = !loaded_q || (fmt_in != last_fmt_q);

  assign rd_red_o    = rd_entry.red;
  assign rd_green_o  = rd_entry.green;
  assign rd_blue_o   = rd_entry.blue;
  assign rd_transp_o = rd_entry.transp;

endmodule

// File: rtl/pal_loader_chk.sv
module pal_loader_chk #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             valid_i,
  input logic [1:0]       fmt_i,
  input logic             ready_o,
  input logic             done_o,
  input logic             reload_req_o,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             half,
  input logic [1:0]       lat_fmt
);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);

  assert_idle_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !half) |-> !wr_en);

  assert_half_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && valid_i && !start_i && lat_fmt == 2'd0) |=> !ready_o);

  assert_idx_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (!wr_en || wr_idx == IDX_W'($past(wr_idx) + 1'b1)));

  assert_start_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && $stable(fmt_i)) |=> !reload_req_o);

endmodule

bind pal_loader pal_loader_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (pal_start_i),
  .valid_i      (word_valid_i),
  .fmt_i        (pal_fmt_i),
  .ready_o      (word_ready_o),
  .done_o       (load_done_o),
  .reload_req_o (reload_req_o),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .half         (half),
  .lat_fmt      (lat_fmt)
);

// File: tb/test_pal_loader.sv
module test_pal_loader;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl_word_i = '0;
  logic [1:0]  pal_fmt_i = '0;
  logic        mono_i = 1'b0;
  logic        pal_start_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_ready_o, load_done_o, reload_req_o;
  logic [7:0]  rd_idx_i = '0;
  logic [7:0]  rd_red_o, rd_green_o, rd_blue_o;
  logic        rd_transp_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pal_loader i_pal_loader (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_word_i(ctrl_word_i), .pal_fmt_i(pal_fmt_i),
    .mono_i(mono_i), .pal_start_i(pal_start_i), .word_valid_i(word_valid_i),
    .word_i(word_i), .word_ready_o(word_ready_o), .load_done_o(load_done_o),
    .reload_req_o(reload_req_o), .rd_idx_i(rd_idx_i), .rd_red_o(rd_red_o),
    .rd_green_o(rd_green_o), .rd_blue_o(rd_blue_o), .rd_transp_o(rd_transp_o)
  );

  // ---------------- reference model ----------------
  logic [24:0] m_pal [256];
  logic [24:0] m_rd;
  bit          m_busy, m_half, m_done, m_loaded, m_mono;
  int          m_cnt, m_idx;
  logic [1:0]  m_fmt, m_last_fmt;
  logic [15:0] m_hi;

  function automatic logic [24:0] expect_entry(logic [31:0] w, logic [1:0] f, bit mono);
    int r, g, b, t;
    if (f == 2'd0) begin
      t = 0;
      if (mono) begin r = w & 255; g = r; b = r; end
      else begin
        r = ((w >> 11) & 31) << 3;
        g = ((w >> 5) & 63) << 2;
        b = (w & 31) << 3;
      end
    end else begin
      t = (w >> 24) & 1;
      if (mono) begin r = w & 255; g = r; b = r; end
      else if (f == 2'd1) begin
        r = ((w >> 19) & 31) << 3; g = ((w >> 10) & 63) << 2; b = ((w >> 3) & 31) << 3;
      end else if (f == 2'd2) begin
        r = ((w >> 18) & 63) << 2; g = ((w >> 10) & 63) << 2; b = ((w >> 2) & 63) << 2;
      end else begin
        r = (w >> 16) & 255; g = (w >> 8) & 255; b = w & 255;
      end
    end
    return {t[0], r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic int count_for(logic [31:0] c);
    int code;
    code = {28'd0, c[29], c[26:24]};
    if (code == 1) return 4;
    if (code == 2) return 16;
    if (code == 3) return 256;
    return 0;
  endfunction

  task automatic model_write(logic [31:0] raw);
    m_pal[m_idx] = expect_entry(raw, m_fmt, m_mono);
    m_idx = m_idx + 1;
    m_cnt = m_cnt - 1;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) m_pal[i] = '0;
      m_rd = '0; m_busy = 0; m_half = 0; m_done = 0; m_loaded = 0;
      m_mono = 0; m_cnt = 0; m_idx = 0; m_fmt = '0; m_last_fmt = '0; m_hi = '0;
    end else begin
      m_rd   = m_pal[rd_idx_i];
      m_done = 0;
      if (pal_start_i) begin
        m_cnt = count_for(ctrl_word_i);
        m_busy = (m_cnt != 0); m_done = (m_cnt == 0);
        m_idx = 0; m_half = 0; m_fmt = pal_fmt_i; m_mono = mono_i;
        m_loaded = 1; m_last_fmt = pal_fmt_i;
      end else if (m_half) begin
        model_write({16'd0, m_hi});
        m_half = 0;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
      end else if (m_busy && word_valid_i) begin
        model_write(m_fmt == 2'd0 ? {16'd0, word_i[15:0]} : word_i);
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
        else if (m_fmt == 2'd0) begin m_half = 1; m_hi = word_i[31:16]; end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [24:0] rd_bus();
    return {rd_transp_o, rd_red_o, rd_green_o, rd_blue_o};
  endfunction

  bit cmp_on = 0;
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && cmp_on) begin
      check("R9 ready", {31'd0, word_ready_o}, {31'd0, m_busy && !m_half});
      check("R8 done", {31'd0, load_done_o}, {31'd0, m_done});
      check("R10 reload_req", {31'd0, reload_req_o},
            {31'd0, !m_loaded || (pal_fmt_i != m_last_fmt)});
      check("R11 read data", {7'd0, rd_bus()}, {7'd0, m_rd});
    end
  end

  function automatic logic [31:0] next_word();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg ^ {lcg[15:0], lcg[31:16]};
  endfunction

  task automatic do_load(input logic [31:0] ctrl, input logic [1:0] fmt, input bit mono,
                         input int exp_words, input int exp_gap, input string tag);
    int acc, gap;
    @(negedge clk_i);
    ctrl_word_i = ctrl; pal_fmt_i = fmt; mono_i = mono; pal_start_i = 1'b1;
    @(negedge clk_i);
    pal_start_i = 1'b0;
    acc = 0;
    for (int c = 0; c < 1200 && acc < exp_words; c++) begin
      word_valid_i = 1'b1;
      word_i = next_word();
      if (word_ready_o) acc++;
      @(negedge clk_i);
    end
    word_valid_i = 1'b0;
    gap = 1;
    while (!load_done_o && gap < 8) begin
      @(negedge clk_i);
      gap++;
    end
    check({tag, " words accepted"}, acc, exp_words);
    check("R8 done gap", gap, exp_gap);
  endtask

  task automatic rd_check(input int idx, input string tag);
    @(negedge clk_i);
    rd_idx_i = idx[7:0];
    @(negedge clk_i);
    #1;
    check(tag, {7'd0, rd_bus()}, {7'd0, m_pal[idx]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [24:0] snap;
    int acc;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R12: reset state
    check("R12 ready after reset", {31'd0, word_ready_o}, 32'd0);
    check("R12 done after reset", {31'd0, load_done_o}, 32'd0);
    check("R12 read after reset", {7'd0, rd_bus()}, 32'd0);
    check("R10 req after reset", {31'd0, reload_req_o}, 32'd1);
    cmp_on = 1;
    rd_check(200, "R12 entry cleared");

    // R1/R5: 256-entry load, layout 3
    do_load(32'h0300_0000, 2'd3, 0, 256, 1, "R1 depth3");
    rd_check(0, "R5 layout3 entry0");
    rd_check(255, "R5 layout3 entry255");
    rd_check(77, "R11 lookup");

    // R10: layout changed since last load
    @(negedge clk_i); pal_fmt_i = 2'd1; #1;
    check("R10 req on change", {31'd0, reload_req_o}, 32'd1);

    // R3: 4 entries, layout 1
    do_load(32'h0100_0000, 2'd1, 0, 4, 1, "R1 depth1");
    #1;
    check("R10 req cleared", {31'd0, reload_req_o}, 32'd0);
    for (int i = 0; i < 4; i++) rd_check(i, "R3 layout1");
    rd_check(4, "R1 entry4 untouched");

    // R4: 16 entries, layout 2
    do_load(32'h0200_0000, 2'd2, 0, 16, 1, "R1 depth2");
    rd_check(3, "R4 layout2");
    rd_check(15, "R4 layout2 last");
    rd_check(16, "R1 entry16 untouched");

    // R2/R7: layout 0, two entries per word
    do_load(32'h0200_0000, 2'd0, 0, 8, 2, "R7 layout0");
    rd_check(0, "R2 low half");
    rd_check(1, "R2 high half");
    rd_check(14, "R7 entry14");
    rd_check(15, "R7 entry15");

    // R6: mono in layouts 0 and 3
    do_load(32'h0100_0000, 2'd0, 1, 2, 2, "R6 mono0");
    rd_check(1, "R6 mono layout0");
    do_load(32'h0100_0000, 2'd3, 1, 4, 1, "R6 mono3");
    rd_check(2, "R6 mono layout3");

    // R1: bit 29 makes the code 9 -> nothing loaded
    snap = m_pal[0];
    do_load(32'h2100_0000, 2'd3, 0, 0, 1, "R1 code9");
    rd_check(0, "R1 code9 table unchanged");
    check("R1 code9 entry0", {7'd0, m_pal[0]}, {7'd0, snap});

    // R9: words offered while idle
    acc = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk_i);
      word_valid_i = 1'b1; word_i = next_word();
      if (word_ready_o) acc++;
    end
    @(negedge clk_i);
    word_valid_i = 1'b0;
    check("R9 idle words taken", acc, 0);
    rd_check(0, "R9 entry0 after idle words");
    check("R9 entry0 unchanged", {7'd0, rd_bus()}, {7'd0, snap});

    repeat (3) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule